// File: doc/BRIEF.md
# Double-Edge Camera Word Capture by Slot Enables

A camera launches one data word on the rising edge and one on the falling edge of its own slow clock, so each camera period carries two words. This block captures both words using a system clock that runs at exactly four times the camera clock. It derives no clock of its own. All rate reduction happens through clock enables in the fast domain, so every fast-domain register sits on the one fast clock.

A single flip-flop on the camera clock inverts itself on every rising camera edge. The fast domain passes that toggle through a two-flop synchronizer and one further stage. The XOR of the last two stages marks each camera period with a one-cycle pulse. That pulse reloads a 2-bit slot counter to zero, and the counter then wraps modulo four. Decoding slots 1 and 3 places a capture enable in the middle of each half-period. Because the enables are locked to the recovered edge, their phase is always the same, unlike a flip-flop clock divider that settles on a random phase.

After each second-half capture, the two words of the period leave the block together as one paired word, with a one-cycle valid strobe.

Top module: `ddr_slot_capture`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first camera rising edge has been marked, `edge_mark`, `cap_first`, `cap_second` and `pair_valid` are 0 and `pair_data` is all zeros.
- R2: If a camera rising edge falls after fast rising edge k and before k+1, then `edge_mark` is high for exactly the one fast cycle that follows fast edge k+2. No other cycle of that camera period has it high.
- R3: The marker reloads the slot counter to 0, and the counter advances by one per fast cycle modulo 4. `cap_first` is high in slot 1, that is, in the fast cycle two cycles after each marker cycle.
- R4: `cap_second` is high in slot 3, four cycles after the first marker. This is the same cycle in which the next camera period's marker appears.
- R5: `cam_data` is sampled at the fast edge that ends each enabled cycle. `pair_data[2*DATA_W-1:DATA_W]` holds the first-half word and `pair_data[DATA_W-1:0]` holds the second-half word of the same camera period.
- R6: `pair_valid` is high for exactly one fast cycle, the cycle after each `cap_second` cycle.
- R7: `pair_data` keeps its value while `pair_valid` is low. Changes of `cam_data` outside the two enabled cycles have no effect on it.
- R8: After the camera clock pauses and resumes with a different phase, without reset, the enables and the paired words follow the new phase. This holds from the fourth fast cycle after the first new camera rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | System clock, four times the camera clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cam_clk | input | 1 | Camera clock |
| cam_data | input | DATA_W | Camera word, changing on both camera edges |
| edge_mark | output | 1 | One-cycle pulse per recovered camera period |
| cap_first | output | 1 | Capture enable for the first-half word |
| cap_second | output | 1 | Capture enable for the second-half word |
| pair_data | output | 2*DATA_W | First-half word (upper) and second-half word (lower) |
| pair_valid | output | 1 | One-cycle strobe for a new `pair_data` |

## Verification
The marker that reloads the slot counter always lands in the same fast cycle as the second-half capture of the previous period. A steadily running camera clock therefore provokes the collision in every period. The bench judges it by requiring `edge_mark` and `cap_second` both high in that cycle. It also requires that the paired word which follows still carries both words of the old period, and that `cap_first` comes exactly two cycles later. A resynchronisation run shifts the camera phase by two fast cycles, so that a marker also arrives while the counter is in a stale slot.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
  // Slot index at a given quarter of a camera period of `ratio` fast cycles.
  function automatic int unsigned quarter_slot(int unsigned ratio, int unsigned quarter);
    return (ratio * quarter) / 4;
  endfunction
endpackage

// File: rtl/dc_reset_sync.sv
module dc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dc_cam_toggle.sv
module dc_cam_toggle (
  input  logic cam_clk,
  input  logic rst_n,
  output logic tog_o
);
  logic tog_q;
  logic tog_d;

  always_comb begin
    tog_d = ~tog_q;
  end

  always_ff @(posedge cam_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/dc_edge_marker.sv
module dc_edge_marker #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_i,
  output logic mark_o
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;

  for (genvar g = 0; g < CHAIN; g++) begin : g_chain
    if (g == 0) begin : g_head
      assign chain_d[g] = tog_i;
    end else begin : g_body
      assign chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign mark_o = chain_q[CHAIN-2] ^ chain_q[CHAIN-1];

  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mark_o |=> !mark_o); // R2
endmodule

// File: rtl/dc_slot_counter.sv
module dc_slot_counter #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_i,
  output logic cap_first_o,
  output logic cap_second_o
);
  import ddr_cap_pkg::*;

  localparam int CNT_W = $clog2(RATIO);
  localparam logic [CNT_W-1:0] FIRST_SLOT  = CNT_W'(quarter_slot(RATIO, 1));
  localparam logic [CNT_W-1:0] SECOND_SLOT = CNT_W'(quarter_slot(RATIO, 3));
  localparam logic [CNT_W-1:0] LAST_SLOT   = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_step;
  logic             lock_q, lock_d;

  if ((RATIO & (RATIO - 1)) == 0) begin : g_pow2_wrap
    assign cnt_step = cnt_q + 1'b1;
  end else begin : g_cmp_wrap
    assign cnt_step = (cnt_q == LAST_SLOT) ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    lock_d = lock_q | mark_i;
    if (mark_i)      cnt_d = '0;
    else if (lock_q) cnt_d = cnt_step;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign cap_first_o  = lock_q && (cnt_q == FIRST_SLOT);
  assign cap_second_o = lock_q && (cnt_q == SECOND_SLOT);

  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |=> !cap_first_o && !cap_second_o); // R3
  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cap_second_o |-> $past(cap_first_o, 2)); // R4
endmodule

// File: rtl/dc_word_pair.sv
module dc_word_pair #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_first_i,
  input  logic                  cap_second_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic [2*DATA_W-1:0]   pair_o,
  output logic                  valid_o
);
  logic [DATA_W-1:0]   first_q, first_d;
  logic [2*DATA_W-1:0] pair_q, pair_d;
  logic                vld_q, vld_d;

  always_comb begin
    first_d = cap_first_i  ? data_i : first_q;
    pair_d  = cap_second_i ? {first_q, data_i} : pair_q;
    vld_d   = cap_second_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      pair_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      first_q <= first_d;
      pair_q  <= pair_d;
      vld_q   <= vld_d;
    end
  end

  assign pair_o  = pair_q;
  assign valid_o = vld_q;

  AST_VALID_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(cap_second_i)); // R6
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(pair_o)); // R7
endmodule

// File: rtl/ddr_slot_capture.sv
module ddr_slot_capture #(
  parameter int DATA_W      = 8,
  parameter int RATIO       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_fast,
  input  logic                rst_n,
  input  logic                cam_clk,
  input  logic [DATA_W-1:0]   cam_data,
  output logic                edge_mark,
  output logic                cap_first,
  output logic                cap_second,
  output logic [2*DATA_W-1:0] pair_data,
  output logic                pair_valid
);
  logic rst_fast_n;
  logic tog;

  dc_reset_sync #(.STAGES(2)) u_rst (
    .clk     (clk_fast),
    .rst_n_i (rst_n),
    .rst_n_o (rst_fast_n)
  );

  dc_cam_toggle u_tog (
    .cam_clk (cam_clk),
    .rst_n   (rst_n),
    .tog_o   (tog)
  );

  dc_edge_marker #(.SYNC_STAGES(SYNC_STAGES)) u_mark (
    .clk    (clk_fast),
    .rst_n  (rst_fast_n),
    .tog_i  (tog),
    .mark_o (edge_mark)
  );

  dc_slot_counter #(.RATIO(RATIO)) u_slot (
    .clk          (clk_fast),
    .rst_n        (rst_fast_n),
    .mark_i       (edge_mark),
    .cap_first_o  (cap_first),
    .cap_second_o (cap_second)
  );

  dc_word_pair #(.DATA_W(DATA_W)) u_pair (
    .clk          (clk_fast),
    .rst_n        (rst_fast_n),
    .cap_first_i  (cap_first),
    .cap_second_i (cap_second),
    .data_i       (cam_data),
    .pair_o       (pair_data),
    .valid_o      (pair_valid)
  );

  AST_NO_EARLY_PAIR: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
    pair_valid |-> !cap_first); // R6
endmodule

// File: tb/test_ddr_slot_capture.sv
`timescale 1ns/1ps
module test_ddr_slot_capture;
  localparam int W = 8;

  logic           clk_fast = 1'b0;
  logic           rst_n    = 1'b0;
  logic           cam_clk  = 1'b0;
  logic [W-1:0]   cam_data = '0;
  logic           edge_mark, cap_first, cap_second, pair_valid;
  logic [2*W-1:0] pair_data;

  ddr_slot_capture #(.DATA_W(W)) i_ddr_slot_capture (
    .clk_fast   (clk_fast),
    .rst_n      (rst_n),
    .cam_clk    (cam_clk),
    .cam_data   (cam_data),
    .edge_mark  (edge_mark),
    .cap_first  (cap_first),
    .cap_second (cap_second),
    .pair_data  (pair_data),
    .pair_valid (pair_valid)
  );

  always #4 clk_fast = ~clk_fast;

  int n = 0;
  always @(posedge clk_fast) n = n + 1;

  int checks = 0, errors = 0;
  logic [W-1:0] wa [0:511];
  logic [W-1:0] wb [0:511];
  int k0 = 0, chk_from = 0, chk_to = -1, d = 0, j = 0;
  bit in_reset_chk = 1'b1, resync = 1'b0, have_pair = 1'b0;
  logic exp_edge, exp_f, exp_s, exp_v;
  logic [2*W-1:0] exp_pair, last_pair = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, n, act, exp);
    end
  endtask

  function automatic string tg(input string r);
    return resync ? {"R8/", r} : r;
  endfunction

  always @(negedge clk_fast) begin
    if (in_reset_chk) begin
      chk({edge_mark, cap_first, cap_second, pair_valid} == 4'b0 && pair_data == '0, "R1",
          {edge_mark, cap_first, cap_second, pair_valid, pair_data}, 0);
    end else if (n >= chk_from && n <= chk_to) begin
      d = n - k0;
      exp_edge = (d >= 2) && (d % 4 == 2);
      exp_f    = (d >= 4) && (d % 4 == 0);
      exp_s    = (d >= 6) && (d % 4 == 2);
      exp_v    = (d >= 7) && (d % 4 == 3);
      chk(edge_mark == exp_edge, tg("R2"), edge_mark, exp_edge);
      chk(cap_first == exp_f, tg("R3"), cap_first, exp_f);
      chk(cap_second == exp_s, tg("R4"), cap_second, exp_s);
      chk(pair_valid == exp_v, tg("R6"), pair_valid, exp_v);
      if (exp_v) begin
        j = (d - 7) / 4;
        exp_pair = {wa[j+1], wb[j+1]};
        chk(pair_data == exp_pair, tg("R5"), pair_data, exp_pair);
        last_pair = exp_pair;
        have_pair = 1'b1;
      end else if (have_pair) begin
        chk(pair_data == last_pair, tg("R7"), pair_data, last_pair);
      end else if (!resync) begin
        chk(pair_data == '0, "R1", pair_data, 0);
      end
    end
  end

  task automatic drive_cam(input int periods);
    for (int p = 0; p < periods; p++) begin
      @(posedge clk_fast); #2;
      cam_clk = 1'b1; cam_data = wa[p];
      repeat (2) @(posedge clk_fast); #2;
      cam_clk = 1'b0; cam_data = wb[p];
      @(posedge clk_fast);
    end
  endtask

  task automatic start_run(input int periods, input int from_ofs);
    @(posedge clk_fast); #1;
    k0 = n + 1;
    chk_from = k0 + from_ofs;
    chk_to = k0 + 4 * periods - 1;
    have_pair = 1'b0;
    drive_cam(periods);
  endtask

  task automatic do_reset(input int idle);
    @(posedge clk_fast); #1;
    in_reset_chk = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(posedge clk_fast); #1;
    rst_n = 1'b1;
    repeat (idle) @(posedge clk_fast); #1;
    in_reset_chk = 1'b0;
  endtask

  initial begin
    // R1: reset and idle camera, then all 256 word values in both halves
    do_reset(12);
    for (int p = 0; p < 258; p++) begin
      wa[p] = W'(p);
      wb[p] = ~W'(p);
    end
    start_run(258, 0);

    for (int ofs = 0; ofs < 3; ofs++) begin
      do_reset(9 + ofs);
      for (int p = 0; p < 40; p++) begin
        wa[p] = W'(p * 29 + 3 + ofs);
        wb[p] = W'(p * 113 + 77 + ofs);
      end
      start_run(40, 0);
    end

    // R8: pause and resume with the camera phase shifted by two fast cycles
    repeat (6) @(posedge clk_fast);
    resync = 1'b1;
    for (int p = 0; p < 40; p++) begin
      wa[p] = W'(p * 7 + 200);
      wb[p] = W'(p * 57 + 11);
    end
    start_run(40, 4);

    repeat (4) @(posedge clk_fast);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule